// File: doc/BRIEF.md
# Input-Change Interrupt Generator

This block watches a bank of general-purpose pins, split into byte-wide ports, and raises an interrupt request when any pin set as an input no longer matches the level held for it in that port's input snapshot. The request is modelled as a pull-low enable for an open-drain line. A 1 on `irq_pull_low` means the line is pulled low and an interrupt is pending. A 0 means the line is released. There is no separate pending flag. The request follows the pins, so it drops again when a changed input goes back to its snapshot level.

The host bus logic pulses one read-acknowledge strobe per port when it finishes reading that port's input register. The strobe recaptures that port's snapshot and clears that port's share of the request. Other ports are not affected.

Live pins pass through one sampling register before they are compared with the snapshot or captured into it. Because of this, a pin that toggles during the read cycle is not lost: it raises the request again once the read completes. Port p holds pin bits [p*8+7 : p*8], so port 0 holds bits 7..0 and port 1 holds bits 15..8.

Top module: `icg_input_change_irq`

## Requirements
- R1: A synchronous active-high reset loads every snapshot and the pin sampler with the pin levels present during reset, so `irq_pull_low` is 0 after reset for any pin pattern.
- R2: When an input pin (`dir_is_in` bit = 1) changes, `irq_pull_low` stays 0 after the first rising edge and is 1 after the second rising edge.
- R3: A pin whose `dir_is_in` bit is 0 (output) never causes `irq_pull_low` to rise, however it toggles.
- R4: When a changed input pin returns to its snapshot level, `irq_pull_low` is 0 after the second rising edge, provided no other mismatch remains.
- R5: A one-cycle pulse on `rd_ack[p]` captures the sampled pins of port p into its snapshot. It removes port p's contribution after that rising edge, and the request stays low while the pins hold still.
- R6: A pulse on `rd_ack[0]` leaves a request caused by port 1 asserted, and a pulse on `rd_ack[1]` leaves a request caused by port 0 asserted.
- R7: If an input pin of port p changes in the same cycle as the `rd_ack[p]` pulse, the request is 0 after that edge and is 1 again after the next edge.
- R8: Direction masking is applied on every cycle. Switching an already mismatched pin from output to input makes `irq_pull_low` 1 after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NUM_PORTS*PORT_W | Live pin levels; port p holds bits [p*PORT_W+PORT_W-1 : p*PORT_W] |
| dir_is_in | input | NUM_PORTS*PORT_W | Per-pin direction, 1 = input, 0 = output |
| rd_ack | input | NUM_PORTS | One-cycle strobe per port, marking the end of a read of that port's input register |
| irq_pull_low | output | 1 | 1 pulls the open-drain interrupt line low; 0 releases it |

## Verification
The bench times each change exactly. A design that compares the raw pins instead of the sampled pins would raise the request one edge early, and one that registered the merge would raise it one edge late. Port isolation is tested both ways. A shared clear would drop a request that the other port still owns. A pin toggle that coincides with a read must bring the request back: a snapshot taken from the live pins would swallow that change for good. Output-configured pins are toggled, and a mismatched pin is then switched to input. Masking applied at the wrong place shows up either as a false request or as one that never rises.

// File: rtl/icg_pkg.sv
package icg_pkg;

    // Snapshot update selected for one port in a given cycle.
    typedef enum logic [1:0] {
        SNAP_HOLD  = 2'd0,
        SNAP_SEED  = 2'd1,   // reset: load the live pins
        SNAP_RECAP = 2'd2    // read acknowledge: load the sampled pins
    } snap_act_e;

    // Reset wins over a read; otherwise a read recaptures.
    function automatic snap_act_e pick_snap_act(input logic rst_i, input logic rd_i);
        if (rst_i)     return SNAP_SEED;
        else if (rd_i) return SNAP_RECAP;
        else           return SNAP_HOLD;
    endfunction

endpackage

// File: rtl/icg_pin_sample.sv
module icg_pin_sample #(
    parameter int PIN_W = 16
) (
    input  logic             clk,
    input  logic [PIN_W-1:0] pin_level,
    output logic [PIN_W-1:0] pin_sync
);

    // One register stage between the live pins and the comparison logic.
    always_ff @(posedge clk) begin
        pin_sync <= pin_level;
    end

endmodule

// File: rtl/icg_port_watch.sv
module icg_port_watch
    import icg_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] pin_raw,
    input  logic [PORT_W-1:0] pin_sync,
    input  logic [PORT_W-1:0] dir_in,
    input  logic              rd_ack,
    output logic              pend
);

    logic [PORT_W-1:0] snap_q;
    logic [PORT_W-1:0] diff_masked;
    snap_act_e         act;

    assign act         = pick_snap_act(rst, rd_ack);
    assign diff_masked = (pin_sync ^ snap_q) & dir_in;

    always_ff @(posedge clk) begin
        unique case (act)
            SNAP_SEED:  snap_q <= pin_raw;
            SNAP_RECAP: snap_q <= pin_sync;
            default:    snap_q <= snap_q;
        endcase
    end

    // A read clears this port's share at once; later mismatches
    // appear on the following edge.
    always_ff @(posedge clk) begin
        if (act != SNAP_HOLD) pend <= 1'b0;
        else                  pend <= |diff_masked;
    end

    // R5: a read acknowledge removes this port's contribution.
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> !pend);

    // R5: the snapshot takes the sampled pins seen at the read.
    a_r5_snap_capture: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> (snap_q == $past(pin_sync)));

    // R4: without a read the snapshot never moves, so returning pins match again.
    a_r4_snap_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_ack |=> $stable(snap_q));

endmodule

// File: rtl/icg_irq_merge.sv
module icg_irq_merge #(
    parameter int NUM_PORTS = 2
) (
    input  logic [NUM_PORTS-1:0] port_pend,
    output logic                 irq_pull_low
);

    // Wired-OR of all port requests onto the one open-drain line.
    assign irq_pull_low = |port_pend;

endmodule

// File: rtl/icg_input_change_irq.sv
module icg_input_change_irq #(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_level,
    input  logic [NUM_PORTS*PORT_W-1:0]   dir_is_in,
    input  logic [NUM_PORTS-1:0]          rd_ack,
    output logic                          irq_pull_low
);

    localparam int PIN_W = NUM_PORTS * PORT_W;

    logic [PIN_W-1:0]     pin_sync;
    logic [NUM_PORTS-1:0] port_pend;

    icg_pin_sample #(.PIN_W(PIN_W)) u_sample (
        .clk       (clk),
        .pin_level (pin_level),
        .pin_sync  (pin_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        icg_port_watch #(.PORT_W(PORT_W)) u_watch (
            .clk      (clk),
            .rst      (rst),
            .pin_raw  (pin_level[p*PORT_W +: PORT_W]),
            .pin_sync (pin_sync[p*PORT_W +: PORT_W]),
            .dir_in   (dir_is_in[p*PORT_W +: PORT_W]),
            .rd_ack   (rd_ack[p]),
            .pend     (port_pend[p])
        );
    end

    icg_irq_merge #(.NUM_PORTS(NUM_PORTS)) u_merge (
        .port_pend    (port_pend),
        .irq_pull_low (irq_pull_low)
    );

    // R3: with every pin set as output the line is released after the edge.
    a_r3_outputs_quiet: assert property (@(posedge clk) disable iff (rst)
        (dir_is_in == '0) |=> !irq_pull_low);

endmodule

// File: tb/test_icg_input_change_irq.sv
module test_icg_input_change_irq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pin_level = 16'hA5C3;
    logic [15:0] dir_is_in = 16'hFFFF;
    logic [1:0]  rd_ack = 2'b00;
    logic        irq_pull_low;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    icg_input_change_irq i_icg_input_change_irq (
        .clk          (clk),
        .rst          (rst),
        .pin_level    (pin_level),
        .dir_is_in    (dir_is_in),
        .rd_ack       (rd_ack),
        .irq_pull_low (irq_pull_low)
    );

    task automatic check(input string req, input logic exp);
        checks++;
        if (irq_pull_low !== exp) begin
            errors++;
            $display("FAIL %s: irq_pull_low=%b expected=%b at %0t", req, irq_pull_low, exp, $time);
        end
    endtask

    // n rising edges, then sample at the following falling edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_port(input int p);
        rd_ack[p] = 1'b1;
        step(1);
        rd_ack = 2'b00;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
        check("R1 after reset", 1'b0);
        step(3);
        check("R1 idle", 1'b0);
    endtask

    task automatic t_change_and_return;
        pin_level[3] = ~pin_level[3];
        step(1);
        check("R2 one edge", 1'b0);
        step(1);
        check("R2 two edges", 1'b1);
        pin_level[3] = ~pin_level[3];
        step(1);
        check("R4 one edge", 1'b1);
        step(1);
        check("R4 returned", 1'b0);
    endtask

    task automatic t_outputs;
        dir_is_in = 16'hFF00;
        pin_level[7:0] = ~pin_level[7:0];
        step(3);
        check("R3 port0 outputs toggled", 1'b0);
        pin_level[7:0] = ~pin_level[7:0];
        step(3);
        dir_is_in = 16'hFFFF;
        step(1);
        check("R3 restored", 1'b0);
    endtask

    task automatic t_read_clear;
        pin_level[12] = ~pin_level[12];
        step(2);
        check("R5 raised", 1'b1);
        read_port(1);
        check("R5 cleared", 1'b0);
        step(3);
        check("R5 stays low", 1'b0);
    endtask

    task automatic t_isolation;
        pin_level[2] = ~pin_level[2];
        step(2);
        read_port(1);
        check("R6 port1 read keeps port0", 1'b1);
        read_port(0);
        check("R6 port0 read clears", 1'b0);
        pin_level[9] = ~pin_level[9];
        step(2);
        read_port(0);
        check("R6 port0 read keeps port1", 1'b1);
        read_port(1);
        check("R6 port1 read clears", 1'b0);
    endtask

    task automatic t_read_race;
        rd_ack[0] = 1'b1;
        pin_level[5] = ~pin_level[5];
        step(1);
        rd_ack = 2'b00;
        check("R7 cleared at read", 1'b0);
        step(1);
        check("R7 change not lost", 1'b1);
        read_port(0);
        check("R7 second read clears", 1'b0);
    endtask

    task automatic t_dir_switch;
        dir_is_in = 16'hFFFE;
        pin_level[0] = ~pin_level[0];
        step(3);
        check("R3 output pin toggled", 1'b0);
        dir_is_in = 16'hFFFF;
        step(1);
        check("R8 switched to input", 1'b1);
        read_port(0);
        check("R8 read clears", 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_change_and_return();
        t_outputs();
        t_read_clear();
        t_isolation();
        t_read_race();
        t_dir_switch();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule